// File: doc/BRIEF.md
# Combinational Integer Square Root Array

This block returns the integer square root of an unsigned word, meaning the floor of the true root, together with the remainder left after the root squared is taken away. It has no clock and no state. A change on the input passes through a fixed array of subtract-or-pass cells and settles on the outputs within the same cycle. The block can sit between pipeline registers that the user supplies.

The array has one row per root bit and works from the most significant bit downward. Each row appends the next two input bits to the running remainder. It then subtracts a trial value built from the root bits already decided, followed by the bits `01`. When the subtraction produces no borrow, the root bit is 1 and the difference becomes the new remainder. Otherwise the root bit is 0 and the extended remainder passes through unchanged. The borrow that leaves the top of a row drives the multiplexor of every cell in that row. Where a trial bit is a constant 0 or 1, the cell is elaborated as a reduced variant that computes the same function.

`DATA_W` sets the input width and must be even. The root is `DATA_W/2` bits wide and the remainder is `DATA_W/2+1` bits wide.

Top module: `isqrt_array`

## Requirements
- R1: For every input value, `root_o` equals the largest integer r with r*r <= `data_i`.
- R2: `root_o`*`root_o` never exceeds `data_i`.
- R3: (`root_o`+1)*(`root_o`+1) is always greater than `data_i`.
- R4: `rem_o` equals `data_i` - `root_o`*`root_o`, taken as an unsigned value that is never negative.
- R5: `rem_o` never exceeds 2*`root_o`, so it fits in `DATA_W/2+1` bits.
- R6: Boundary inputs: 0 gives root 0 and remainder 0. The all-ones input gives root 2^(DATA_W/2)-1 and remainder 2*(2^(DATA_W/2)-1). Inputs 1 and 3 give root 1 with remainders 0 and 2.
- R7: A perfect square n*n gives root n and remainder 0. The value n*n-1 (n >= 1) gives root n-1 and remainder 2n-2.
- R8: The block is purely combinational. Outputs settle in the same cycle that the input changes, and they depend only on the present input, not on earlier inputs.
- R9: The same array structure, widened through `DATA_W`, meets R1 and R4 at a 16-bit input width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | DATA_W | Unsigned radicand |
| root_o | output | DATA_W/2 | Floor of the square root |
| rem_o | output | DATA_W/2+1 | data_i minus root_o squared |

## Verification
The bench builds two copies of the block, one with `DATA_W` = 8 and one with `DATA_W` = 16, and sweeps every input value of both. At 8 bits the sweep covers all 256 radicands. At 16 bits it covers all 65536 radicands, which exercises eight rows of cells, the longer borrow chains, and the reduced cell variants at every row depth. For each value the root and remainder are compared with a floor root computed incrementally in the bench. Directed cases for the boundaries, the perfect squares and their predecessors, and the independence of the result from earlier inputs come first.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;
  // subtrahend kind seen by one cell
  typedef enum logic [1:0] {SUB_VAR, SUB_ZERO, SUB_ONE} sub_mode_e;

  // trial = {partial_root, 2'b01}; bit j is variable only over known root bits
  function automatic sub_mode_e trial_mode(input int j, input int lvl);
    if (j == 0) return SUB_ONE;
    if (j >= 2 && (j - 2) < lvl) return SUB_VAR;
    return SUB_ZERO;
  endfunction
endpackage

// File: rtl/isqrt_sm_cell.sv
module isqrt_sm_cell
  import isqrt_pkg::*;
#(
  parameter sub_mode_e MODE = SUB_VAR
) (
  input  logic a_i,
  input  logic b_i,
  input  logic bin_i,
  input  logic pass_i,
  output logic d_o,
  output logic bout_o
);
  logic diff;

  generate
    if (MODE == SUB_ZERO) begin : g_b0
      logic unused_b;
      assign unused_b = b_i;
      assign diff     = a_i ^ bin_i;
      assign bout_o   = ~a_i & bin_i;
    end else if (MODE == SUB_ONE) begin : g_b1
      logic unused_b;
      assign unused_b = b_i;
      assign diff     = ~(a_i ^ bin_i);
      assign bout_o   = ~a_i | bin_i;
    end else begin : g_full
      assign diff   = a_i ^ b_i ^ bin_i;
      assign bout_o = (~a_i & b_i) | (~a_i & bin_i) | (b_i & bin_i);
    end
  endgenerate

  // row borrow set: trial failed, keep operand
  assign d_o = pass_i ? a_i : diff;
endmodule

// File: rtl/isqrt_row.sv
module isqrt_row
  import isqrt_pkg::*;
#(
  parameter int ROW_W  = 6,
  parameter int ROOT_W = 4,
  parameter int LVL    = 0
) (
  input  logic [ROW_W-1:0]  rem_i,
  input  logic [ROOT_W-1:0] root_i,
  output logic [ROW_W-1:0]  rem_o,
  output logic              bit_o
);
  logic [ROW_W:0]   brw;
  logic [ROW_W-1:0] trial;
  logic             pass;
  logic             unused_root;

  assign brw[0]      = 1'b0;
  assign pass        = brw[ROW_W];
  assign bit_o       = ~brw[ROW_W];
  assign unused_root = ^root_i;

  generate
    for (genvar j = 0; j < ROW_W; j++) begin : g_col
      localparam sub_mode_e M = trial_mode(j, LVL);
      if (M == SUB_VAR) begin : g_var
        assign trial[j] = root_i[j-2];
      end else begin : g_const
        assign trial[j] = (M == SUB_ONE);
      end
      isqrt_sm_cell #(.MODE(M)) u_cell (
        .a_i   (rem_i[j]),
        .b_i   (trial[j]),
        .bin_i (brw[j]),
        .pass_i(pass),
        .d_o   (rem_o[j]),
        .bout_o(brw[j+1])
      );
    end
  endgenerate
endmodule

// File: rtl/isqrt_array.sv
module isqrt_array #(
  parameter int DATA_W = 8,
  localparam int ROOT_W = DATA_W / 2,
  localparam int REM_W  = ROOT_W + 1
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [ROOT_W-1:0] root_o,
  output logic [REM_W-1:0]  rem_o
);
  localparam int ROW_W = ROOT_W + 2;

  logic [ROW_W-1:0]  rem_q  [ROOT_W+1];
  logic [ROOT_W-1:0] part_q [ROOT_W+1];

  assign rem_q[0]  = '0;
  assign part_q[0] = '0;

  generate
    for (genvar i = 0; i < ROOT_W; i++) begin : g_row
      localparam int K = ROOT_W - 1 - i;
      logic [ROW_W-1:0] rem_ext;
      logic             rbit;
      logic             unused_hi;

      // previous remainder < 2^ROOT_W, top two bits always zero here
      assign rem_ext   = {rem_q[i][ROW_W-3:0], data_i[2*K+1 -: 2]};
      assign unused_hi = ^{rem_q[i][ROW_W-1 -: 2], part_q[i][ROOT_W-1]};

      isqrt_row #(
        .ROW_W (ROW_W),
        .ROOT_W(ROOT_W),
        .LVL   (i)
      ) u_row (
        .rem_i (rem_ext),
        .root_i(part_q[i]),
        .rem_o (rem_q[i+1]),
        .bit_o (rbit)
      );

      assign part_q[i+1] = {part_q[i][ROOT_W-2:0], rbit};
    end
  endgenerate

  logic unused_top;
  assign unused_top = rem_q[ROOT_W][ROW_W-1];

  assign root_o = part_q[ROOT_W];
  assign rem_o  = rem_q[ROOT_W][REM_W-1:0];
endmodule

// File: rtl/isqrt_array_chk.sv
module isqrt_array_chk #(
  parameter int DATA_W = 8,
  localparam int ROOT_W = DATA_W / 2,
  localparam int REM_W  = ROOT_W + 1
) (
  input logic [DATA_W-1:0] data_i,
  input logic [ROOT_W-1:0] root_o,
  input logic [REM_W-1:0]  rem_o
);
  longint unsigned d, r, m;
  assign d = 64'(data_i);
  assign r = 64'(root_o);
  assign m = 64'(rem_o);

  always_comb begin
    AST_ROOT_NOT_HIGH: assert (r * r <= d) else $error("root too high"); // R2
    AST_ROOT_NOT_LOW: assert ((r + 1) * (r + 1) > d) else $error("root too low"); // R3
    AST_REM_EXACT: assert (m == d - r * r) else $error("remainder mismatch"); // R4
    AST_REM_BOUND: assert (m <= 2 * r) else $error("remainder bound"); // R5
  end
endmodule

bind isqrt_array isqrt_array_chk #(.DATA_W(DATA_W)) u_chk (
  .data_i(data_i),
  .root_o(root_o),
  .rem_o (rem_o)
);

// File: tb/isqrt_array_test.sv
`timescale 1ns/1ps
module isqrt_array_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [7:0]  d8;
  logic [3:0]  r8;
  logic [4:0]  m8;
  logic [15:0] d16;
  logic [7:0]  r16;
  logic [8:0]  m16;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  isqrt_array #(.DATA_W(8))  uut   (.data_i(d8),  .root_o(r8),  .rem_o(m8));
  isqrt_array #(.DATA_W(16)) uut_w (.data_i(d16), .root_o(r16), .rem_o(m16));

  task automatic check(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic apply(input longint x8, input longint x16);
    @(posedge clk);
    d8  = 8'(x8);
    d16 = 16'(x16);
    @(negedge clk);
  endtask

  task automatic t_idle;
    apply(0, 0);
    check("R6 zero root w8", r8, 0);
    check("R6 zero rem w8", m8, 0);
    check("R6 zero root w16", r16, 0);
    check("R6 zero rem w16", m16, 0);
  endtask

  task automatic t_bounds;
    apply(255, 65535);
    check("R6 max root w8", r8, 15);
    check("R6 max rem w8", m8, 30);
    check("R6 max root w16", r16, 255);
    check("R6 max rem w16", m16, 510);
    apply(1, 3);
    check("R6 one root", r8, 1);
    check("R6 one rem", m8, 0);
    check("R6 three root", r16, 1);
    check("R6 three rem", m16, 2);
  endtask

  task automatic t_squares;
    for (int n = 1; n < 16; n++) begin
      apply(n * n, n * n - 1);
      check("R7 square root", r8, n);
      check("R7 square rem", m8, 0);
      check("R7 pred root", r16, n - 1);
      check("R7 pred rem", m16, 2 * n - 2);
    end
  endtask

  task automatic t_history;
    longint r_a, m_a;
    apply(200, 40000);
    r_a = r8;
    m_a = m8;
    check("R8 same cycle root", r8, 14);
    check("R8 same cycle rem w16", m16, 0);
    apply(17, 1);
    check("R8 change root", r8, 4);
    apply(200, 40000);
    check("R8 history root", r8, r_a);
    check("R8 history rem", m8, m_a);
  endtask

  task automatic t_sweep8;
    longint rr = 0;
    for (int x = 0; x < 256; x++) begin
      while ((rr + 1) * (rr + 1) <= x) rr++;
      apply(x, 0);
      check("R1 root w8", r8, rr);
      check("R4 rem w8", m8, x - rr * rr);
      check("R2 r*r<=x", longint'(r8) * r8 <= x, 1);
      check("R3 (r+1)^2>x", (longint'(r8) + 1) * (r8 + 1) > x, 1);
      check("R5 rem<=2r", m8 <= 2 * longint'(r8), 1);
    end
  endtask

  task automatic t_sweep16;
    longint rr = 0;
    for (int x = 0; x < 65536; x++) begin
      while ((rr + 1) * (rr + 1) <= x) rr++;
      apply(0, x);
      check("R9 root w16", r16, rr);
      check("R9 rem w16", m16, x - rr * rr);
    end
  endtask

  initial begin
    d8  = '0;
    d16 = '0;
    t_idle();
    t_bounds();
    t_squares();
    t_history();
    t_sweep8();
    t_sweep16();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule